// File: doc/BRIEF.md
# E1 Frame and Multiframe Synchronizer

This block watches a recovered 2.048 Mb/s E1 bit stream, one bit per clock enable, and finds where each 256-bit frame begins. It first locates the frame alignment word in time slot 0 with a three-frame acceptance rule. When the CRC-4 option is on, it then searches for the 16-frame CRC-4 multiframe inside a bounded window.

If that window runs out without a lock, it counts a failed attempt and goes back to a fresh frame search. After lock it reports the time slot and bit of the most recent bit, a strobe at each frame start and the multiframe frame number. It also drops both locks when the frame word is repeatedly corrupted, or when an external CRC checker reports too many errored codewords.

Top module: `e1_frame_sync`

## Requirements
- R1: After reset `los` is 1 and `fas_sync`, `mf_sync`, `frame_pulse` and `crc_tries` are 0. `los` stays 1 while no frame lock is held.
- R2: Bits arrive first-bit-first, and the first bit of a time slot is bit 1. The alignment word is bits 2..8 of time slot 0, equal to 0011011. Bit 1 is not examined. The block searches one bit at a time. Frame lock is declared when the word is seen in frame N, bit 2 of time slot 0 is 1 in frame N+1, and the word is seen again in frame N+2. `fas_sync` rises on the edge that takes in bit 8 of time slot 0 of frame N+2.
- R3: If bit 2 of time slot 0 is 0 in frame N+1, the candidate is dropped and the search resumes sliding, so lock comes two frames later than it otherwise would.
- R4: While locked, `ts_idx`/`bit_idx` give the time slot (0..31) and the bit (0..7, where 0 is bit 1) of the last bit taken in. `frame_pulse` is high for one cycle after the first bit of each frame is taken in.
- R5: A cycle with `bit_en` low does not move the position outputs.
- R6: Frame lock is lost on the third errored alignment word in a row. Fewer consecutive errors, followed by a good word, keep the lock.
- R7: With `crc_en` high and frame lock held, multiframe lock (`mf_sync`) is declared one cycle after a second alignment pattern 001011 completes exactly 16 frames after the first. That pattern is taken from bit 1 of time slot 0 of frames 1,3,5,7,9,11. `mf_frame` is then 11 and steps at each frame start. With `crc_en` low, `mf_sync` stays 0.
- R8: If multiframe lock is not found within 64 frames of frame lock, `crc_tries` increments by one and frame lock is dropped one cycle later.
- R9: `crc_tries` returns to 0 when multiframe lock is declared.
- R10: While multiframe locked, codeword reports (`cw_valid`, with `cw_err` marking a bad one) are counted in windows of 1000. The 915th error in a window drops both locks one cycle later. A window that closes with 914 errors keeps the lock and starts a new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Recovered bit valid this cycle |
| bit_in | input | 1 | Recovered line bit |
| crc_en | input | 1 | Enable CRC-4 multiframe search |
| cw_valid | input | 1 | A CRC-4 codeword check result is present |
| cw_err | input | 1 | That codeword was in error |
| los | output | 1 | No frame lock held |
| fas_sync | output | 1 | Frame lock held |
| mf_sync | output | 1 | CRC-4 multiframe lock held |
| frame_pulse | output | 1 | One-cycle strobe after a frame's first bit |
| ts_idx | output | 5 | Time slot of last bit |
| bit_idx | output | 3 | Bit within the slot of last bit |
| mf_frame | output | 4 | Frame number within the multiframe |
| crc_tries | output | 6 | Failed multiframe search count |

## Verification
Frame lock, loss of frame lock, the position outputs and `frame_pulse` change on the same edge that takes in the deciding bit. The bench therefore checks them at the falling edge just after that bit, and again one bit earlier to confirm nothing happened early. Multiframe lock, the timeout step of `crc_tries` and the codeword-driven resync each pass through one extra register, so their outputs move one edge after the deciding bit or report. The bench checks the old value right after the deciding bit and the new value one edge later. Every expected edge is derived from a stream index: frame times 256 plus bit.

// File: rtl/e1s_pkg.sv
package e1s_pkg;
    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_CHK_NF = 2'd1,
        ST_CHK_F  = 2'd2,
        ST_LOCK   = 2'd3
    } e1s_state_e;

    localparam logic [6:0] ALIGN_WORD = 7'b0011011;
    localparam logic [5:0] MF_WORD    = 6'b001011;
endpackage

// File: rtl/e1s_mf_track.sv
module e1s_mf_track #(
    parameter int MF_FRAMES  = 16,
    parameter int TMO_FRAMES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic tick,
    input  logic odd_frame,
    input  logic mbit,
    output logic found,
    output logic timeout
);
    import e1s_pkg::*;

    localparam int SPACING = MF_FRAMES / 2;
    localparam int GAP_W   = $clog2(SPACING + 1);
    localparam int TMO_W   = $clog2(TMO_FRAMES + 1);

    typedef struct packed {
        logic [5:0]       sr;
        logic             armed;
        logic [GAP_W-1:0] gap;
        logic [TMO_W-1:0] tmr;
        logic             found;
        logic             tmo;
    } trk_t;

    trk_t q, d;

    always_comb begin
        logic [5:0]       sr_n;
        logic [TMO_W-1:0] tmr_n;
        logic             hit;
        d     = q;
        d.found = 1'b0;
        d.tmo   = 1'b0;
        sr_n  = {q.sr[4:0], mbit};
        tmr_n = q.tmr + TMO_W'(1);
        hit   = 1'b0;
        if (!active) begin
            d.sr    = '1;
            d.armed = 1'b0;
            d.gap   = '0;
            d.tmr   = '0;
        end else if (tick) begin
            d.tmr = tmr_n;
            if (odd_frame) begin
                d.sr = sr_n;
                if (q.armed && q.gap != GAP_W'(SPACING))
                    d.gap = q.gap + GAP_W'(1);
                if (sr_n == MF_WORD) begin
                    if (q.armed && q.gap == GAP_W'(SPACING - 1)) begin
                        hit = 1'b1;
                    end else begin
                        d.armed = 1'b1;
                        d.gap   = '0;
                    end
                end
            end
            if (hit)
                d.found = 1'b1;
            else if (tmr_n == TMO_W'(TMO_FRAMES))
                d.tmo = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.sr    <= '1;
            q.armed <= 1'b0;
            q.gap   <= '0;
            q.tmr   <= '0;
            q.found <= 1'b0;
            q.tmo   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign found   = q.found;
    assign timeout = q.tmo;
endmodule

// File: rtl/e1s_cw_monitor.sv
module e1s_cw_monitor #(
    parameter int CW_WIN   = 1000,
    parameter int CW_LIMIT = 915
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic cw_valid,
    input  logic cw_err,
    output logic resync
);
    localparam int CW_W = $clog2(CW_WIN + 1);

    typedef struct packed {
        logic [CW_W-1:0] seen;
        logic [CW_W-1:0] errs;
        logic            resync;
    } mon_t;

    mon_t q, d;

    always_comb begin
        logic [CW_W-1:0] seen_n;
        logic [CW_W-1:0] errs_n;
        d        = q;
        d.resync = 1'b0;
        seen_n   = q.seen + CW_W'(1);
        errs_n   = q.errs + CW_W'(cw_err);
        if (!active) begin
            d.seen = '0;
            d.errs = '0;
        end else if (cw_valid) begin
            if (errs_n >= CW_W'(CW_LIMIT)) begin
                d.resync = 1'b1;
                d.seen   = '0;
                d.errs   = '0;
            end else if (seen_n == CW_W'(CW_WIN)) begin
                d.seen = '0;
                d.errs = '0;
            end else begin
                d.seen = seen_n;
                d.errs = errs_n;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign resync = q.resync;
endmodule

// File: rtl/e1_frame_sync.sv
module e1_frame_sync #(
    parameter int FRAME_BITS = 256,
    parameter int FAS_MISS   = 3,
    parameter int MF_FRAMES  = 16,
    parameter int TMO_FRAMES = 64,
    parameter int CW_WIN     = 1000,
    parameter int CW_LIMIT   = 915,
    parameter int CNT_W      = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bit_en,
    input  logic                            bit_in,
    input  logic                            crc_en,
    input  logic                            cw_valid,
    input  logic                            cw_err,
    output logic                            los,
    output logic                            fas_sync,
    output logic                            mf_sync,
    output logic                            frame_pulse,
    output logic [$clog2(FRAME_BITS)-4:0]   ts_idx,
    output logic [2:0]                      bit_idx,
    output logic [$clog2(MF_FRAMES)-1:0]    mf_frame,
    output logic [CNT_W-1:0]                crc_tries
);
    import e1s_pkg::*;

    localparam int POS_W   = $clog2(FRAME_BITS);
    localparam int MISS_W  = $clog2(FAS_MISS);
    localparam int MF_W    = $clog2(MF_FRAMES);
    localparam int MF_LAST = 2 * $bits(MF_WORD) - 1;

    typedef struct packed {
        e1s_state_e       st;
        logic [7:0]       sr;
        logic [POS_W-1:0] pos;
        logic             fas_fr;
        logic [MISS_W-1:0] miss;
        logic             mf_lock;
        logic [MF_W-1:0]  mff;
        logic [CNT_W-1:0] tries;
        logic             pulse;
    } sync_t;

    sync_t q, d;

    logic [7:0]       sr_n;
    logic [POS_W-1:0] pos_n;
    logic             ts0_end;
    logic             mf_search;
    logic             mf_found;
    logic             mf_tmo;
    logic             cw_resync;

    assign sr_n      = {q.sr[6:0], bit_in};
    assign pos_n     = (q.pos == POS_W'(FRAME_BITS - 1)) ? '0 : q.pos + POS_W'(1);
    assign ts0_end   = (pos_n == POS_W'(7));
    assign mf_search = (q.st == ST_LOCK) && crc_en && !q.mf_lock;

    e1s_mf_track #(
        .MF_FRAMES (MF_FRAMES),
        .TMO_FRAMES(TMO_FRAMES)
    ) u_mf (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (mf_search),
        .tick     (bit_en && ts0_end),
        .odd_frame(!q.fas_fr),
        .mbit     (sr_n[7]),
        .found    (mf_found),
        .timeout  (mf_tmo)
    );

    e1s_cw_monitor #(
        .CW_WIN  (CW_WIN),
        .CW_LIMIT(CW_LIMIT)
    ) u_cw (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (q.mf_lock),
        .cw_valid(cw_valid),
        .cw_err  (cw_err),
        .resync  (cw_resync)
    );

    always_comb begin
        logic word_ok;
        d       = q;
        d.pulse = 1'b0;
        word_ok = (sr_n[6:0] == ALIGN_WORD);
        if (bit_en) begin
            d.sr  = sr_n;
            d.pos = pos_n;
            if (pos_n == '0) begin
                d.fas_fr = !q.fas_fr;
                if (q.mf_lock) d.mff = q.mff + MF_W'(1);
                if (q.st == ST_LOCK) d.pulse = 1'b1;
            end
            case (q.st)
                ST_HUNT: begin
                    if (word_ok) begin
                        d.st     = ST_CHK_NF;
                        d.pos    = POS_W'(7);
                        d.fas_fr = 1'b1;
                    end
                end
                ST_CHK_NF: begin
                    if (ts0_end) d.st = sr_n[6] ? ST_CHK_F : ST_HUNT;
                end
                ST_CHK_F: begin
                    d.miss = '0;
                    if (ts0_end) d.st = word_ok ? ST_LOCK : ST_HUNT;
                end
                default: begin
                    if (ts0_end && q.fas_fr) begin
                        if (word_ok) begin
                            d.miss = '0;
                        end else if (q.miss == MISS_W'(FAS_MISS - 1)) begin
                            d.st      = ST_HUNT;
                            d.miss    = '0;
                            d.mf_lock = 1'b0;
                        end else begin
                            d.miss = q.miss + MISS_W'(1);
                        end
                    end
                end
            endcase
        end
        if (mf_tmo && q.st == ST_LOCK) begin
            d.st      = ST_HUNT;
            d.miss    = '0;
            d.mf_lock = 1'b0;
            d.tries   = q.tries + CNT_W'(1);
        end
        if (mf_found && d.st == ST_LOCK) begin
            d.mf_lock = 1'b1;
            d.mff     = MF_W'(MF_LAST);
            d.tries   = '0;
        end
        if (cw_resync) begin
            d.st      = ST_HUNT;
            d.miss    = '0;
            d.mf_lock = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign los         = (q.st != ST_LOCK);
    assign fas_sync    = (q.st == ST_LOCK);
    assign mf_sync     = q.mf_lock;
    assign frame_pulse = q.pulse;
    assign ts_idx      = q.pos[POS_W-1:3];
    assign bit_idx     = q.pos[2:0];
    assign mf_frame    = q.mff;
    assign crc_tries   = q.tries;
endmodule

// File: rtl/e1_frame_sync_chk.sv
module e1_frame_sync_chk #(
    parameter int TS_W  = 5,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             los,
    input logic             fas_sync,
    input logic             mf_sync,
    input logic             frame_pulse,
    input logic [TS_W-1:0]  ts_idx,
    input logic [2:0]       bit_idx,
    input logic [CNT_W-1:0] crc_tries
);
    p_mf_needs_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mf_sync |-> (fas_sync && !los));

    p_lock_at_slot0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fas_sync) |-> (ts_idx == '0 && bit_idx == 3'd7));

    p_pulse_at_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |-> (fas_sync && ts_idx == '0 && bit_idx == 3'd0));

    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(ts_idx) && $stable(bit_idx)));

    p_tries_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(crc_tries) |-> (crc_tries == '0 ||
                                 (crc_tries - $past(crc_tries)) == CNT_W'(1)));

    p_tries_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mf_sync) |-> (crc_tries == '0));

    p_drop_together_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mf_sync) |-> !fas_sync);
endmodule

bind e1_frame_sync e1_frame_sync_chk #(
    .TS_W (POS_W - 3),
    .CNT_W(CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .los        (los),
    .fas_sync   (fas_sync),
    .mf_sync    (mf_sync),
    .frame_pulse(frame_pulse),
    .ts_idx     (ts_idx),
    .bit_idx    (bit_idx),
    .crc_tries  (crc_tries)
);

// File: tb/e1_frame_sync_tb.sv
module e1_frame_sync_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       crc_en = 1'b0;
    logic       cw_valid = 1'b0;
    logic       cw_err = 1'b0;
    logic       los, fas_sync, mf_sync, frame_pulse;
    logic [4:0] ts_idx;
    logic [2:0] bit_idx;
    logic [3:0] mf_frame;
    logic [5:0] crc_tries;

    int checks = 0;
    int errors = 0;
    int g = 0;
    bit done = 1'b0;

    logic [255:0] bad_word_set;
    int bad_nf_frame;
    int mf_bad_until;

    localparam int NVEC = 6;
    localparam int VEC_OFF  [NVEC] = '{0, 1, 100, 255, 300, 600};
    localparam int VEC_LOCK [NVEC] = '{519, 519, 1031, 1031, 1031, 1543};

    always #10 clk = ~clk;

    e1_frame_sync u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .crc_en(crc_en), .cw_valid(cw_valid), .cw_err(cw_err),
        .los(los), .fas_sync(fas_sync), .mf_sync(mf_sync),
        .frame_pulse(frame_pulse), .ts_idx(ts_idx), .bit_idx(bit_idx),
        .mf_frame(mf_frame), .crc_tries(crc_tries)
    );

    function automatic logic stream_bit(int gi);
        int f, p, m;
        logic [7:0] b;
        logic mb;
        logic [5:0] mw;
        f = gi / 256;
        p = gi % 256;
        mw = 6'b001011;
        if (p >= 8) return 1'b1;
        if (f % 2 == 0) begin
            b = 8'b1001_1011;
            if (f < 256 && bad_word_set[f]) b = 8'b1001_1111;
        end else begin
            m = f % 16;
            mb = (m < 12) ? mw[5 - (m - 1) / 2] : 1'b1;
            if (f < mf_bad_until) mb = 1'b1;
            b = {mb, (f == bad_nf_frame) ? 1'b0 : 1'b1, 1'b0, 5'b11111};
        end
        return b[7 - p];
    endfunction

    task automatic chk(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst_n = 1'b0; bit_en = 1'b0; cw_valid = 1'b0; cw_err = 1'b0;
        bad_word_set = '0; bad_nf_frame = -1; mf_bad_until = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_to(int target);
        while (g < target) begin
            @(negedge clk);
            bit_en = 1'b1;
            bit_in = stream_bit(g);
            g++;
        end
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic run_cw(int n, int nerr);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_en = 1'b1;
            bit_in = stream_bit(g);
            g++;
            cw_valid = 1'b1;
            cw_err = (i >= n - nerr);
        end
        @(negedge clk);
        bit_en = 1'b0; cw_valid = 1'b0; cw_err = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        reset_dut();
        chk("R1", los, 1, "los after reset");
        chk("R1", fas_sync, 0, "fas_sync after reset");
        chk("R1", mf_sync, 0, "mf_sync after reset");
        chk("R1", frame_pulse, 0, "frame_pulse after reset");
        chk("R1", crc_tries, 0, "crc_tries after reset");

        // R2: lock edge for several starting offsets
        for (int v = 0; v < NVEC; v++) begin
            reset_dut();
            crc_en = 1'b0;
            g = VEC_OFF[v];
            run_to(VEC_LOCK[v]);
            chk("R2", fas_sync, 0, "no lock before third word");
            chk("R1", los, 1, "los during search");
            run_to(VEC_LOCK[v] + 1);
            chk("R2", fas_sync, 1, "lock on third word");
            chk("R2", {ts_idx, bit_idx}, 7, "position at lock");
        end

        // R3: bad second-frame bit 2 delays lock by two frames
        reset_dut();
        bad_nf_frame = 1; g = 0;
        run_to(520);
        chk("R3", fas_sync, 0, "rejected candidate");
        run_to(1031);
        chk("R3", fas_sync, 0, "before delayed lock");
        run_to(1032);
        chk("R3", fas_sync, 1, "delayed lock");

        // R4, R5, R6, R7 (crc off)
        reset_dut();
        crc_en = 1'b0;
        bad_word_set[10] = 1'b1; bad_word_set[12] = 1'b1;
        bad_word_set[20] = 1'b1; bad_word_set[22] = 1'b1; bad_word_set[24] = 1'b1;
        g = 0;
        run_to(600);
        chk("R4", ts_idx, 10, "time slot");
        chk("R4", bit_idx, 7, "bit in slot");
        repeat (10) @(negedge clk);
        chk("R5", {ts_idx, bit_idx}, 87, "held while bit_en low");
        run_to(768);
        chk("R4", frame_pulse, 0, "no strobe before frame start");
        run_to(769);
        chk("R4", frame_pulse, 1, "strobe at frame start");
        chk("R4", {ts_idx, bit_idx}, 0, "position at frame start");
        @(negedge clk);
        chk("R4", frame_pulse, 0, "strobe one cycle");
        run_to(6151);
        chk("R6", fas_sync, 1, "two errors then good keeps lock");
        chk("R7", mf_sync, 0, "no multiframe with crc off");
        run_to(6152);
        chk("R6", fas_sync, 0, "third error drops lock");
        chk("R6", los, 1, "los after loss");

        // R7, R10: multiframe lock and codeword resync
        reset_dut();
        crc_en = 1'b1; g = 0;
        run_to(520);
        chk("R7", mf_sync, 0, "no multiframe at frame lock");
        run_to(11016);
        chk("R7", mf_sync, 0, "before second pattern");
        run_to(11017);
        chk("R7", mf_sync, 1, "multiframe lock");
        chk("R7", mf_frame, 11, "multiframe position");
        run_to(11265);
        chk("R7", mf_frame, 12, "multiframe steps");
        run_cw(1000, 914);
        chk("R10", mf_sync, 1, "914 errors keep lock");
        run_cw(914, 914);
        chk("R10", mf_sync, 1, "914 errors in new window");
        run_cw(1, 1);
        chk("R10", fas_sync, 1, "resync one cycle later");
        run_to(g + 1);
        chk("R10", mf_sync, 0, "resync drops multiframe");
        chk("R10", fas_sync, 0, "resync drops frame lock");
        chk("R10", crc_tries, 0, "resync not a timeout");

        // R8, R9: timeout then later lock
        reset_dut();
        crc_en = 1'b1; mf_bad_until = 80; g = 0;
        run_to(16904);
        chk("R8", fas_sync, 1, "before timeout");
        chk("R8", crc_tries, 0, "count before timeout");
        run_to(16905);
        chk("R8", fas_sync, 0, "timeout restarts search");
        chk("R8", crc_tries, 1, "count after timeout");
        run_to(17928);
        chk("R8", fas_sync, 1, "relock after timeout");
        run_to(27400);
        chk("R9", mf_sync, 0, "before second lock");
        chk("R9", crc_tries, 1, "count held");
        run_to(27401);
        chk("R9", mf_sync, 1, "multiframe lock");
        chk("R9", crc_tries, 0, "count cleared");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule